// File: doc/BRIEF.md
# Push-Button Master Volume Controller

This block turns three active-low push buttons (louder, softer, silence) into a saturating master volume code and a mute flag. The buttons are assumed to be debounced and synchronous to `clk` already. A press of louder or softer moves the level by one code straight away. If the button stays down, the level keeps moving: first after a hold delay, then at a faster repeat rate. Both intervals are counted in pulses of a slow `tick` strobe, for example one pulse per millisecond.

Two mute formats are available, chosen by `two_button`. With the bit clear, the dedicated silence button toggles the mute on each press. With the bit set, the silence pin has no effect, and pressing louder and softer together mutes. The two presses count as together when the second one comes within a short tick window of the first. In both formats, a single louder or softer press unmutes and also applies its step. While `enable` is low, the buttons have no effect and the outputs hold their values.

`CHORD_TICKS` must lie between 1 and `HOLD_TICKS`. `HOLD_TICKS` and `REPEAT_TICKS` must be at least 1.

Top module: `vol_button_ctrl`

## Requirements
- R1: During and after reset, `volume` equals `RESET_VOL` (32 by default) and `muted` is 0.
- R2: A falling edge on `up_n` while `down_n` is high raises `volume` by one at the next clock edge. A falling edge on `down_n` while `up_n` is high lowers it by one.
- R3: `volume` saturates: it stays at 63 when a step up is requested and at 0 when a step down is requested. It never wraps around.
- R4: While exactly one of `up_n`/`down_n` stays low, a second step follows on the `HOLD_TICKS`-th `tick` pulse after the press. After that, one further step follows every `REPEAT_TICKS` pulses.
- R5: With `two_button` = 0, each falling edge on `mute_n` inverts `muted`.
- R6: With `two_button` = 1, `mute_n` has no effect on any output.
- R7: With `two_button` = 1, `muted` is set when both buttons become low. This applies when they fall in the same cycle, or when the second falls fewer than `CHORD_TICKS` tick pulses after the first. With `two_button` = 0, pressing both never mutes.
- R8: While both `up_n` and `down_n` are low, `volume` does not change. With `two_button` = 1, a second press that comes `CHORD_TICKS` or more pulses after the first does not mute.
- R9: A step caused by `up_n` or `down_n` clears `muted` in the same clock edge that applies the step, in either format.
- R10: While `enable` is 0, no button or tick changes `volume` or `muted`.
- R11: When one button of a held pair is released, the one still held waits a full `HOLD_TICKS` delay before it steps. It gets no immediate step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Function enable; buttons are ignored when 0 |
| two_button | input | 1 | Mute format: 0 = toggle button, 1 = both-buttons chord |
| tick | input | 1 | One-cycle timing strobe for hold and repeat intervals |
| up_n | input | 1 | Louder button, active low |
| down_n | input | 1 | Softer button, active low |
| mute_n | input | 1 | Silence button, active low |
| volume | output | VOL_W | Master volume code |
| muted | output | 1 | Mute flag |

## Verification
Almost every state error here becomes visible on `volume` or `muted` within one clock edge of the press that uses it. A wrong edge register shows up as a missing or doubled step, or as a missing or extra toggle, on the cycle after the press. A wrong hold counter or phase flag shows up as a step that lands one or more tick pulses early or late. It also shows up as the chord window misjudged by one pulse, which the bench probes at the exact boundary tick. A bad saturation guard shows up as a wrap from 63 to 0 on the first step past the end.

// File: rtl/vol_button_ctrl.sv
`timescale 1ns/1ps
module vol_button_ctrl #(
  parameter int VOL_W        = 6,
  parameter int RESET_VOL    = 32,
  parameter int HOLD_TICKS   = 500,
  parameter int REPEAT_TICKS = 100,
  parameter int CHORD_TICKS  = 30
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             two_button,
  input  logic             tick,
  input  logic             up_n,
  input  logic             down_n,
  input  logic             mute_n,
  output logic [VOL_W-1:0] volume,
  output logic             muted
);
  localparam int MAX_T = (HOLD_TICKS > REPEAT_TICKS) ? HOLD_TICKS : REPEAT_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] REP_END   = CNT_W'(REPEAT_TICKS - 1);
  localparam logic [CNT_W-1:0] CHORD_LIM = CNT_W'(CHORD_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [VOL_W-1:0] VOL_ONE   = VOL_W'(1);
  localparam logic [VOL_W-1:0] VOL_TOP   = '1;
  localparam logic [VOL_W-1:0] VOL_RST   = VOL_W'(RESET_VOL);

  logic up, dn, mt;
  logic up_d, dn_d, mt_d;
  logic up_edge, dn_edge, mt_edge;
  logic single, limit_hit, step, chord;
  logic rep;
  logic [CNT_W-1:0] cnt;

  assign up = ~up_n;
  assign dn = ~down_n;
  assign mt = ~mute_n;

  assign up_edge = up & ~up_d;
  assign dn_edge = dn & ~dn_d;
  assign mt_edge = mt & ~mt_d;
  assign single  = up ^ dn;

  assign limit_hit = tick && (cnt == (rep ? REP_END : HOLD_END));
  assign step      = enable && single && (up_edge || dn_edge || limit_hit);
  assign chord     = enable && two_button && up && dn && (up_edge || dn_edge)
                     && !rep && (cnt < CHORD_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_d <= 1'b0;
      dn_d <= 1'b0;
      mt_d <= 1'b0;
    end else begin
      up_d <= up;
      dn_d <= dn;
      mt_d <= mt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rep <= 1'b0;
    end else if (!enable || !single || up_edge || dn_edge) begin
      cnt <= '0;
      rep <= 1'b0;
    end else if (tick) begin
      if (limit_hit) begin
        cnt <= '0;
        rep <= 1'b1;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      volume <= VOL_RST;
      muted  <= 1'b0;
    end else if (step) begin
      muted <= 1'b0;
      if (up && volume != VOL_TOP)
        volume <= volume + VOL_ONE;
      else if (dn && volume != '0)
        volume <= volume - VOL_ONE;
    end else if (chord) begin
      muted <= 1'b1;
    end else if (enable && !two_button && mt_edge) begin
      muted <= ~muted;
    end
  end
endmodule

// File: rtl/vol_button_ctrl_chk.sv
`timescale 1ns/1ps
module vol_button_ctrl_chk #(
  parameter int VOL_W = 6
)(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             two_button,
  input logic             up_n,
  input logic             down_n,
  input logic             mute_n,
  input logic [VOL_W-1:0] volume,
  input logic             muted
);
  localparam logic [VOL_W-1:0] ONE = VOL_W'(1);
  localparam logic [VOL_W-1:0] TOP = '1;

  // R3
  vol_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volume == $past(volume)) ||
    ($past(volume) != TOP && volume == $past(volume) + ONE) ||
    ($past(volume) != '0  && volume == $past(volume) - ONE));

  // R2
  up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volume > $past(volume)) |-> (!$past(up_n) && $past(down_n)));

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(volume) && $stable(muted)));

  // R6
  fmt1_mute_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && two_button && up_n && down_n) |=> $stable(muted));

  // R7
  chord_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(muted) && $past(two_button)) |-> (!$past(up_n) && !$past(down_n)));

  // R5
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(muted) && !$past(two_button)) |-> !$past(mute_n));

  // R8
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !up_n && !down_n) |=> $stable(volume));

  // R9
  unmute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volume != $past(volume)) |-> !muted);
endmodule

bind vol_button_ctrl vol_button_ctrl_chk #(.VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .two_button(two_button),
  .up_n(up_n), .down_n(down_n), .mute_n(mute_n),
  .volume(volume), .muted(muted)
);

// File: tb/sim_vol_button_ctrl.sv
`timescale 1ns/1ps
module sim_vol_button_ctrl;
  localparam int HOLD = 4;
  localparam int REP  = 2;
  localparam int CHRD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic two_button = 1'b0;
  logic tick = 1'b0;
  logic up_n = 1'b1;
  logic down_n = 1'b1;
  logic mute_n = 1'b1;
  logic [5:0] volume;
  logic muted;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vol_button_ctrl #(
    .VOL_W(6), .RESET_VOL(32), .HOLD_TICKS(HOLD),
    .REPEAT_TICKS(REP), .CHORD_TICKS(CHRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .two_button(two_button),
    .tick(tick), .up_n(up_n), .down_n(down_n), .mute_n(mute_n),
    .volume(volume), .muted(muted)
  );

  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      clk1();
      tick = 1'b0;
      clk1();
    end
  endtask

  task automatic expect_state(input string req, input int ev, input bit em);
    checks++;
    if (int'(volume) != ev || muted != em) begin
      fails++;
      $display("FAIL %s: volume=%0d muted=%0b expected volume=%0d muted=%0b",
               req, volume, muted, ev, em);
    end
  endtask

  task automatic t_reset();
    expect_state("R1", 32, 1'b0);
  endtask

  task automatic t_single();
    up_n = 1'b0; clk1(); expect_state("R2", 33, 1'b0);
    up_n = 1'b1; clk1(); expect_state("R2", 33, 1'b0);
    down_n = 1'b0; clk1(); expect_state("R2", 32, 1'b0);
    down_n = 1'b1; clk1();
  endtask

  task automatic t_hold();
    up_n = 1'b0; clk1(); expect_state("R4", 33, 1'b0);
    ticks(HOLD - 1); expect_state("R4", 33, 1'b0);
    ticks(1);        expect_state("R4", 34, 1'b0);
    ticks(REP - 1);  expect_state("R4", 34, 1'b0);
    ticks(1);        expect_state("R4", 35, 1'b0);
    up_n = 1'b1; clk1();
    down_n = 1'b0; clk1(); expect_state("R4", 34, 1'b0);
    ticks(HOLD);     expect_state("R4", 33, 1'b0);
    ticks(REP);      expect_state("R4", 32, 1'b0);
    down_n = 1'b1; clk1();
  endtask

  task automatic t_sat();
    up_n = 1'b0; clk1(); ticks(140); expect_state("R3", 63, 1'b0);
    up_n = 1'b1; clk1();
    up_n = 1'b0; clk1(); expect_state("R3", 63, 1'b0);
    up_n = 1'b1; clk1();
    down_n = 1'b0; clk1(); ticks(140); expect_state("R3", 0, 1'b0);
    down_n = 1'b1; clk1();
    down_n = 1'b0; clk1(); expect_state("R3", 0, 1'b0);
    down_n = 1'b1; clk1();
  endtask

  task automatic t_fmt0();
    two_button = 1'b0; clk1();
    mute_n = 1'b0; clk1(); expect_state("R5", 0, 1'b1);
    mute_n = 1'b1; clk1(); expect_state("R5", 0, 1'b1);
    mute_n = 1'b0; clk1(); expect_state("R5", 0, 1'b0);
    mute_n = 1'b1; clk1();
    mute_n = 1'b0; clk1(); expect_state("R5", 0, 1'b1);
    mute_n = 1'b1; clk1();
    up_n = 1'b0; clk1(); expect_state("R9", 1, 1'b0);
    up_n = 1'b1; clk1();
    up_n = 1'b0; down_n = 1'b0; clk1(); expect_state("R7", 1, 1'b0);
    ticks(6); expect_state("R8", 1, 1'b0);
    up_n = 1'b1; down_n = 1'b1; clk1();
  endtask

  task automatic t_fmt1();
    two_button = 1'b1; clk1();
    mute_n = 1'b0; clk1(); expect_state("R6", 1, 1'b0);
    mute_n = 1'b1; clk1(); expect_state("R6", 1, 1'b0);
    up_n = 1'b0; clk1(); expect_state("R2", 2, 1'b0);
    ticks(CHRD - 1);
    down_n = 1'b0; clk1(); expect_state("R7", 2, 1'b1);
    ticks(6); expect_state("R8", 2, 1'b1);
    up_n = 1'b1; down_n = 1'b1; clk1();
    down_n = 1'b0; clk1(); expect_state("R9", 1, 1'b0);
    down_n = 1'b1; clk1();
    up_n = 1'b0; down_n = 1'b0; clk1(); expect_state("R7", 1, 1'b1);
    up_n = 1'b1; down_n = 1'b1; clk1();
    up_n = 1'b0; clk1(); expect_state("R9", 2, 1'b0);
    ticks(CHRD);
    down_n = 1'b0; clk1(); expect_state("R8", 2, 1'b0);
    ticks(5); expect_state("R8", 2, 1'b0);
    up_n = 1'b1; clk1(); expect_state("R11", 2, 1'b0);
    ticks(HOLD - 1); expect_state("R11", 2, 1'b0);
    ticks(1); expect_state("R11", 1, 1'b0);
    down_n = 1'b1; clk1();
  endtask

  task automatic t_enable();
    enable = 1'b0; clk1();
    up_n = 1'b0; clk1(); ticks(HOLD + 2); expect_state("R10", 1, 1'b0);
    up_n = 1'b1; clk1();
    two_button = 1'b0;
    mute_n = 1'b0; clk1(); expect_state("R10", 1, 1'b0);
    mute_n = 1'b1; clk1();
    down_n = 1'b0; clk1(); expect_state("R10", 1, 1'b0);
    down_n = 1'b1; clk1();
    enable = 1'b1; clk1();
    up_n = 1'b0; clk1(); expect_state("R10", 2, 1'b0);
    up_n = 1'b1; clk1();
  endtask

  initial begin
    clk1(); clk1();
    expect_state("R1", 32, 1'b0);
    clk1();
    rst_n = 1'b1;
    clk1();
    t_reset();
    t_single();
    t_hold();
    t_sat();
    t_fmt0();
    t_fmt1();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule